// File: doc/BRIEF.md
# AC-link Codec Register Access Engine

This block is the control path of an AC'97 controller. It lets a host read and write the registers of an external codec over the command and status slots of the AC-link. The host loads two transmit words: an address word for slot 1 and a data word for slot 2. Writing the slot 1 word commits the command. At the next frame boundary the engine places the pending words in the outgoing frame and marks them in the tag slot. For a read, the codec's slot 1 echo and slot 2 data are captured from a later incoming frame and flagged as valid until the host reads them. The engine also drives the codec reset line and a codec-select field.

Serial shifting is not modelled. The link is seen at slot granularity: a one-cycle `frame_strobe` marks each frame boundary. At that edge the engine loads the words for the frame that starts and samples the tag, slot 1 and slot 2 words of the frame that ended. The engine is a three-state machine:
- IDLE: nothing is committed.
- ARMED: a command is waiting for a frame.
- AWAIT: a read request has gone out and the response is awaited.

The transitions are:
- commit: a slot 1 write, from any state, to ARMED.
- send-write: ARMED to IDLE, at a frame that carries a write.
- send-read: ARMED to AWAIT, at a frame that carries a read.
- answer: AWAIT to IDLE, when a slot 1 response is captured.

Host registers, selected by `reg_addr`:
- 0: control.
- 1: slot 1 transmit.
- 2: slot 2 transmit.
- 3: slot 1 receive.
- 4: slot 2 receive.
- 5: status.
- 6: codec reset.

Top module: `acl_codec_engine`

## Requirements
- R1: After reset, every register read through the host port returns 0. `codec_rst_n` is low, `codec_sel` is 0, and `tx_tag`, `tx_slot1` and `tx_slot2` are 0.
- R2: The control register (address 0) reads back as written in bits [6:0]. Its fields are: bit0 global enable, bit1 slot 1 transmit enable, bit2 slot 2 transmit enable, bit3 slot 1 receive enable, bit4 slot 2 receive enable, bits[6:5] codec select, which drives `codec_sel`. `codec_rst_n` follows bit0 of the reset register (address 6) one cycle after the write.
- R3: Writing slot 2 (address 2, word in bits [19:0], data in [19:4]) sets status bit1 (slot 2 busy) and commits nothing. Slot 2 alone is never transmitted.
- R4: Writing slot 1 (address 1; register index in [18:12], bit19 = read) sets status bit0 (slot 1 busy) and arms the engine. At the next `frame_strobe` with global and slot 1 transmit enable set, two things happen:
  - `tx_slot1` carries the word, with `tx_tag` bit15 = frame valid and bit14 = slot 1 valid.
  - For a write with slot 2 busy and enabled, `tx_slot2` carries the slot 2 word and `tx_tag` bit13 is set.
  The busy bit of each sent slot clears. The tx outputs change only at a `frame_strobe`.
- R5: At every `frame_strobe`, `tx_tag` bit15 equals the global enable, and slots not carrying a command are 0. With the global enable clear, nothing is sent and a pending command stays pending.
- R6: A slot whose transmit enable is clear is not sent, and its busy bit stays set. A committed command waits until slot 1 is enabled.
- R7: A read request (bit19 set) transmits slot 1 only, and a busy slot 2 stays busy. After it is sent, status bit4 (awaiting response) is set until a slot 1 response is captured at a later frame.
- R8: At a `frame_strobe`, the response words are captured as follows:
  - `rx_slot1` is captured when `rx_tag` bit14 is set and the global and slot 1 receive enables are set. This sets status bit2.
  - `rx_slot2` is captured likewise with `rx_tag` bit13 and the slot 2 receive enable. This sets status bit3.
  Disabled or unflagged slots are ignored.
- R9: Reading address 3 or 4 returns the captured slot 1 or slot 2 word and clears its valid bit. A capture in the same cycle wins.
- R10: A second slot 1 or slot 2 write before its frame overwrites the pending word. Only the last value is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (clears receive valid on addresses 3, 4) |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from `reg_addr` |
| frame_strobe | input | 1 | One-cycle pulse at each AC-link frame boundary |
| rx_tag | input | 16 | Tag slot of the frame just received |
| rx_slot1 | input | 20 | Slot 1 word of the frame just received |
| rx_slot2 | input | 20 | Slot 2 word of the frame just received |
| tx_tag | output | 16 | Tag slot of the outgoing frame |
| tx_slot1 | output | 20 | Slot 1 word of the outgoing frame |
| tx_slot2 | output | 20 | Slot 2 word of the outgoing frame |
| codec_rst_n | output | 1 | Active-low codec reset |
| codec_sel | output | 2 | Selected codec |

## Verification
The hardest situations to reach are those where a command is held back. Three cases matter:
- A slot 2 word loaded but never committed.
- A committed slot 1 with its transmit enable cleared.
- A slot 2 word left busy behind a read.

The bench reaches each one by changing the control word between a write and the next frame strobe. It then confirms through the status register and the next tag slot that nothing leaked out and that the stalled word goes out once it is enabled and committed. Write and read commands are swept over a spread of register indices and data patterns. A bench codec model echoes each read, and the expected words are computed from the index and data.

// File: rtl/acl_pkg.sv
package acl_pkg;
    localparam int SLOT_W = 20;
    localparam int TAG_W  = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_S1TX = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_S2TX = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_S1RX = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_S2RX = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_RST  = 3'd6;

    localparam int TAG_FRAME = 15;
    localparam int TAG_S1    = 14;
    localparam int TAG_S2    = 13;
    localparam int READ_BIT  = 19;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_AWAIT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [1:0] sel;
        logic       rx2_en;
        logic       rx1_en;
        logic       tx2_en;
        logic       tx1_en;
        logic       glob_en;
    } ctrl_t;
endpackage

// File: rtl/acl_hostregs.sv
module acl_hostregs
    import acl_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int BW = BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BW-1:0]     reg_wdata,
    input  logic              sent1,
    input  logic              sent2,
    input  logic              awaiting,
    input  logic [SW-1:0]     rx1_word,
    input  logic [SW-1:0]     rx2_word,
    input  logic              rx1_valid,
    input  logic              rx2_valid,
    output ctrl_t             ctrl,
    output logic              reset_bit,
    output logic [SW-1:0]     s1tx,
    output logic [SW-1:0]     s2tx,
    output logic              busy1,
    output logic              busy2,
    output logic              commit,
    output logic              rd1,
    output logic              rd2,
    output logic [BW-1:0]     reg_rdata
);
    localparam int CW = $bits(ctrl_t);

    logic wr_s2;

    assign commit = reg_wr && (reg_addr == ADR_S1TX);
    assign wr_s2  = reg_wr && (reg_addr == ADR_S2TX);
    assign rd1    = reg_rd && (reg_addr == ADR_S1RX);
    assign rd2    = reg_rd && (reg_addr == ADR_S2RX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            reset_bit <= 1'b0;
            s1tx      <= '0;
            s2tx      <= '0;
            busy1     <= 1'b0;
            busy2     <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADR_CTRL) ctrl <= ctrl_t'(reg_wdata[CW-1:0]);
            if (reg_wr && reg_addr == ADR_RST)  reset_bit <= reg_wdata[0];
            if (commit) s1tx <= reg_wdata[SW-1:0];
            if (wr_s2)  s2tx <= reg_wdata[SW-1:0];
            busy1 <= (busy1 && !sent1) || commit;
            busy2 <= (busy2 && !sent2) || wr_s2;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL: reg_rdata[CW-1:0] = ctrl;
            ADR_S1TX: reg_rdata[SW-1:0] = s1tx;
            ADR_S2TX: reg_rdata[SW-1:0] = s2tx;
            ADR_S1RX: reg_rdata[SW-1:0] = rx1_word;
            ADR_S2RX: reg_rdata[SW-1:0] = rx2_word;
            ADR_STAT: reg_rdata[4:0]    = {awaiting, rx2_valid, rx1_valid, busy2, busy1};
            ADR_RST:  reg_rdata[0]      = reset_bit;
            default:  reg_rdata         = '0;
        endcase
    end
endmodule

// File: rtl/acl_rx_capture.sv
module acl_rx_capture
    import acl_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int TW = TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_strobe,
    input  ctrl_t         ctrl,
    input  logic [TW-1:0] rx_tag,
    input  logic [SW-1:0] rx_slot1,
    input  logic [SW-1:0] rx_slot2,
    input  logic          rd1,
    input  logic          rd2,
    output logic [SW-1:0] rx1_word,
    output logic [SW-1:0] rx2_word,
    output logic          rx1_valid,
    output logic          rx2_valid,
    output logic          got1
);
    logic got2;

    assign got1 = frame_strobe && ctrl.glob_en && ctrl.rx1_en && rx_tag[TAG_S1];
    assign got2 = frame_strobe && ctrl.glob_en && ctrl.rx2_en && rx_tag[TAG_S2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx1_word  <= '0;
            rx2_word  <= '0;
            rx1_valid <= 1'b0;
            rx2_valid <= 1'b0;
        end else begin
            if (got1) rx1_word <= rx_slot1;
            if (got2) rx2_word <= rx_slot2;
            rx1_valid <= got1 || (rx1_valid && !rd1);
            rx2_valid <= got2 || (rx2_valid && !rd2);
        end
    end
endmodule

// File: rtl/acl_frame_fsm.sv
module acl_frame_fsm
    import acl_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int TW = TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_strobe,
    input  ctrl_t         ctrl,
    input  logic          commit,
    input  logic [SW-1:0] s1tx,
    input  logic [SW-1:0] s2tx,
    input  logic          busy2,
    input  logic          got1,
    output logic          sent1,
    output logic          sent2,
    output logic          awaiting,
    output logic [TW-1:0] tx_tag,
    output logic [SW-1:0] tx_slot1,
    output logic [SW-1:0] tx_slot2
);
    eng_state_e state, state_nx;
    logic       is_read;

    assign is_read  = s1tx[READ_BIT];
    assign sent1    = frame_strobe && ctrl.glob_en && ctrl.tx1_en && (state == ST_ARMED);
    assign sent2    = sent1 && !is_read && busy2 && ctrl.tx2_en;
    assign awaiting = (state == ST_AWAIT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (commit) state_nx = ST_ARMED;
            ST_ARMED: if (commit) state_nx = ST_ARMED;
                      else if (sent1) state_nx = is_read ? ST_AWAIT : ST_IDLE;
            ST_AWAIT: if (commit) state_nx = ST_ARMED;
                      else if (got1) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_tag   <= '0;
            tx_slot1 <= '0;
            tx_slot2 <= '0;
        end else if (frame_strobe) begin
            tx_tag            <= '0;
            tx_tag[TAG_FRAME] <= ctrl.glob_en;
            tx_tag[TAG_S1]    <= sent1;
            tx_tag[TAG_S2]    <= sent2;
            tx_slot1          <= sent1 ? s1tx : '0;
            tx_slot2          <= sent2 ? s2tx : '0;
        end
    end
endmodule

// File: rtl/acl_codec_engine.sv
module acl_codec_engine
    import acl_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int TW = TAG_W,
    parameter int BW = BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BW-1:0]     reg_wdata,
    output logic [BW-1:0]     reg_rdata,
    input  logic              frame_strobe,
    input  logic [TW-1:0]     rx_tag,
    input  logic [SW-1:0]     rx_slot1,
    input  logic [SW-1:0]     rx_slot2,
    output logic [TW-1:0]     tx_tag,
    output logic [SW-1:0]     tx_slot1,
    output logic [SW-1:0]     tx_slot2,
    output logic              codec_rst_n,
    output logic [1:0]        codec_sel
);
    ctrl_t         ctrl;
    logic          reset_bit, busy1, busy2, commit, rd1, rd2;
    logic          sent1, sent2, awaiting, got1, rx1_valid, rx2_valid;
    logic [SW-1:0] s1tx, s2tx, rx1_word, rx2_word;

    assign codec_rst_n = reset_bit;
    assign codec_sel   = ctrl.sel;

    acl_hostregs #(.SW(SW), .BW(BW)) u_regs (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
        .sent1, .sent2, .awaiting, .rx1_word, .rx2_word, .rx1_valid, .rx2_valid,
        .ctrl, .reset_bit, .s1tx, .s2tx, .busy1, .busy2, .commit, .rd1, .rd2,
        .reg_rdata
    );

    acl_rx_capture #(.SW(SW), .TW(TW)) u_rx (
        .clk, .rst_n, .frame_strobe, .ctrl, .rx_tag, .rx_slot1, .rx_slot2,
        .rd1, .rd2, .rx1_word, .rx2_word, .rx1_valid, .rx2_valid, .got1
    );

    acl_frame_fsm #(.SW(SW), .TW(TW)) u_fsm (
        .clk, .rst_n, .frame_strobe, .ctrl, .commit, .s1tx, .s2tx, .busy2, .got1,
        .sent1, .sent2, .awaiting, .tx_tag, .tx_slot1, .tx_slot2
    );
endmodule

// File: rtl/acl_engine_checker.sv
module acl_engine_checker
    import acl_pkg::*;
#(
    parameter int TW = TAG_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_strobe,
    input logic [TW-1:0] tx_tag,
    input logic          busy1,
    input logic          rx1_valid,
    input logic          rd1
);
    // R4: slot 2 only travels with slot 1
    p_slot2_with_slot1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tag[TAG_S2] |-> tx_tag[TAG_S1]);

    // R4: outgoing frame holds between strobes
    p_hold_between_frames_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(tx_tag));

    // R4: slot 1 busy drops only when slot 1 went out
    p_busy_clears_on_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy1) |-> tx_tag[TAG_S1]);

    // R5: no slot is flagged without the frame-valid bit
    p_sent_needs_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tag[TAG_S1] |-> tx_tag[TAG_FRAME]);

    // R8: receive valid rises only at a frame boundary
    p_capture_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx1_valid) |-> $past(frame_strobe));

    // R9: reading slot 1 receive clears its valid bit
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1 && !frame_strobe) |=> !rx1_valid);
endmodule

bind acl_codec_engine acl_engine_checker #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .tx_tag(tx_tag),
    .busy1(busy1), .rx1_valid(rx1_valid), .rd1(rd1)
);

// File: tb/test_acl_codec_engine.sv
module test_acl_codec_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_strobe = 1'b0;
    logic [15:0] rx_tag = '0;
    logic [19:0] rx_slot1 = '0, rx_slot2 = '0;
    logic [15:0] tx_tag;
    logic [19:0] tx_slot1, tx_slot2;
    logic        codec_rst_n;
    logic [1:0]  codec_sel;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    acl_codec_engine i_acl_codec_engine (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .frame_strobe, .rx_tag, .rx_slot1, .rx_slot2,
        .tx_tag, .tx_slot1, .tx_slot2, .codec_rst_n, .codec_sel
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic frame(input logic [15:0] t, input logic [19:0] w1, input logic [19:0] w2);
        @(negedge clk); frame_strobe = 1'b1; rx_tag = t; rx_slot1 = w1; rx_slot2 = w2;
        @(negedge clk); frame_strobe = 1'b0; rx_tag = '0; rx_slot1 = '0; rx_slot2 = '0;
    endtask

    localparam logic [31:0] CTRL_ON = 32'h5F; // all enables, codec select 2

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v); chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 codec_rst_n", {31'b0, codec_rst_n}, 32'h0);
        chk("R1 tx_tag", {16'b0, tx_tag}, 32'h0);
        chk("R1 tx_slot1", {12'b0, tx_slot1}, 32'h0);

        // R2 control and reset register
        wr(3'd6, 32'h1);
        chk("R2 codec_rst_n released", {31'b0, codec_rst_n}, 32'h1);
        wr(3'd0, CTRL_ON);
        rd(3'd0, v); chk("R2 control readback", v, CTRL_ON);
        chk("R2 codec_sel", {30'b0, codec_sel}, 32'h2);

        // R5 idle frame
        frame(16'h0, '0, '0);
        chk("R5 idle tag", {16'b0, tx_tag}, 32'h8000);
        chk("R5 idle slot1", {12'b0, tx_slot1}, 32'h0);

        // R4 write command sweep
        for (int k = 0; k < 8; k++) begin
            logic [6:0]  idx;
            logic [15:0] dat;
            idx = 7'((k * 37 + 5) % 128);
            dat = 16'hA5C3 ^ 16'(k * 16'h1111);
            wr(3'd2, {12'b0, dat, 4'b0});
            wr(3'd1, {13'b0, idx, 12'b0});
            rd(3'd5, v); chk("R3 R4 busy after load", v, 32'h3);
            frame(16'h0, '0, '0);
            chk("R4 write tag", {16'b0, tx_tag}, 32'hE000);
            chk("R4 write slot1", {12'b0, tx_slot1}, {13'b0, idx, 12'b0});
            chk("R4 write slot2", {12'b0, tx_slot2}, {12'b0, dat, 4'b0});
            rd(3'd5, v); chk("R4 busy cleared", v, 32'h0);
            frame(16'h0, '0, '0);
            chk("R4 no repeat", {16'b0, tx_tag}, 32'h8000);
        end

        // R7 R8 R9 read command sweep with codec echo
        for (int k = 0; k < 8; k++) begin
            logic [6:0]  idx;
            logic [15:0] dat;
            idx = 7'((k * 23 + 2) % 128);
            dat = 16'h1234 + 16'(k * 16'h0F0F);
            wr(3'd1, {12'b0, 1'b1, idx, 12'b0});
            frame(16'h0, '0, '0);
            chk("R7 read tag", {16'b0, tx_tag}, 32'hC000);
            chk("R7 read slot1", {12'b0, tx_slot1}, {12'b0, 1'b1, idx, 12'b0});
            rd(3'd5, v); chk("R7 awaiting", v, 32'h10);
            frame(16'hE000, {1'b0, idx, 12'b0}, {dat, 4'b0});
            rd(3'd5, v); chk("R8 valid set, R7 answered", v, 32'hC);
            rd(3'd3, v); chk("R9 slot1 rx word", v, {13'b0, idx, 12'b0});
            rd(3'd4, v); chk("R9 slot2 rx word", v, {12'b0, dat, 4'b0});
            rd(3'd5, v); chk("R9 valid cleared", v, 32'h0);
        end

        // R8 receive enables and tag bits gate capture
        wr(3'd0, 32'h47);
        frame(16'hE000, 20'h12000, 20'h55550);
        rd(3'd5, v); chk("R8 rx disabled ignored", v, 32'h0);
        wr(3'd0, CTRL_ON);
        frame(16'h8000, 20'h12000, 20'h55550);
        rd(3'd5, v); chk("R8 unflagged ignored", v, 32'h0);

        // R6 slot 1 transmit disabled
        wr(3'd0, 32'h5D);
        wr(3'd1, 32'h07000);
        frame(16'h0, '0, '0);
        chk("R6 slot1 held tag", {16'b0, tx_tag}, 32'h8000);
        rd(3'd5, v); chk("R6 slot1 still busy", v, 32'h1);
        wr(3'd0, CTRL_ON);
        frame(16'h0, '0, '0);
        chk("R6 slot1 released", {16'b0, tx_tag}, 32'hC000);
        chk("R6 slot1 word", {12'b0, tx_slot1}, 32'h07000);

        // R6 slot 2 transmit disabled, then R3 slot 2 alone not sent
        wr(3'd0, 32'h5B);
        wr(3'd2, 32'hBEEF0);
        wr(3'd1, 32'h0A000);
        frame(16'h0, '0, '0);
        chk("R6 slot2 suppressed", {16'b0, tx_tag}, 32'hC000);
        rd(3'd5, v); chk("R6 slot2 still busy", v, 32'h2);
        wr(3'd0, CTRL_ON);
        frame(16'h0, '0, '0);
        chk("R3 slot2 alone not sent", {16'b0, tx_tag}, 32'h8000);
        rd(3'd5, v); chk("R3 slot2 busy kept", v, 32'h2);

        // R7 read leaves busy slot 2 behind
        wr(3'd1, 32'h8B000);
        frame(16'h0, '0, '0);
        chk("R7 read omits slot2", {16'b0, tx_tag}, 32'hC000);
        rd(3'd5, v); chk("R7 slot2 busy after read", v, 32'h12);
        frame(16'hC000, 20'h0B000, '0);
        rd(3'd3, v);
        wr(3'd1, 32'h0B000);
        frame(16'h0, '0, '0);
        chk("R4 slot2 joins write", {16'b0, tx_tag}, 32'hE000);
        chk("R4 slot2 word", {12'b0, tx_slot2}, 32'hBEEF0);

        // R10 overwrite before frame
        wr(3'd2, 32'h11110);
        wr(3'd2, 32'h22220);
        wr(3'd1, 32'h03000);
        wr(3'd1, 32'h04000);
        frame(16'h0, '0, '0);
        chk("R10 last slot1 sent", {12'b0, tx_slot1}, 32'h04000);
        chk("R10 last slot2 sent", {12'b0, tx_slot2}, 32'h22220);

        // R5 global enable off
        wr(3'd0, 32'h5E);
        wr(3'd1, 32'h05000);
        frame(16'hE000, 20'h05000, 20'h1);
        chk("R5 global off tag", {16'b0, tx_tag}, 32'h0);
        rd(3'd5, v); chk("R5 pending kept, no capture", v, 32'h1);
        wr(3'd0, CTRL_ON);
        frame(16'h0, '0, '0);
        chk("R5 sent after enable", {16'b0, tx_tag}, 32'hC000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule